// File: doc/BRIEF.md
# Prioritized Interrupt Target Selector

This block picks, for one interrupt target context, which interrupt source should be served next. Each cycle it looks at every source's pending flag, its enable flag for this context and its priority level. It then registers three results: the identity of the best candidate, that candidate's priority, and an interrupt-request line to the hart.

A source counts as a candidate only when it is pending, enabled and has a non-zero priority. Among candidates the highest priority wins. When priorities tie, the smallest identity wins. The context's threshold affects only the request line. The winner's identity is reported whether or not the threshold masks it, so that a claim path can use it directly.

Source identities run from 1 to `N_SRC`. Bit 0 of the pending and enable vectors and field 0 of the priority vector stand for a source that does not exist, and the block ignores them.

Top module: `tgt_sel_top`

## Requirements
- R1: A source whose priority field is 0 is never reported as the winner and never raises `irq_o`.
- R2: Among candidates, the one with the numerically largest priority is reported. Priority 1 is the weakest active level.
- R3: When several candidates share the largest priority, the one with the smallest identity is reported.
- R4: Bit 0 of `pend_i` and `en_i`, and priority field 0, have no effect on any output.
- R5: A source is a candidate only when its bit in `pend_i` and its bit in `en_i` are both 1. Source k uses bit k of each vector and bits [k*PRIO_W +: PRIO_W] of `prio_i`.
- R6: `irq_o` is 1 only when the winner's priority is strictly greater than `thresh_i`. A threshold of 0 passes every non-zero priority.
- R7: `win_id_o` and `win_prio_o` do not depend on `thresh_i`. A winner whose priority is at or below the threshold is still reported, with `irq_o` at 0.
- R8: With no candidate, `win_id_o` and `win_prio_o` are both 0 and `irq_o` is 0.
- R9: All outputs are registered. They reflect the inputs sampled at the previous rising edge and are 0 while `rst_n` is low.
- R10: When the winning source's pending bit clears and no other candidate exceeds the threshold, `irq_o` is 0 after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pend_i | input | N_SRC+1 | Pending flag per source, bit k for source k |
| en_i | input | N_SRC+1 | Enable flag per source for this context |
| prio_i | input | (N_SRC+1)*PRIO_W | Priority fields, field k for source k |
| thresh_i | input | PRIO_W | Context priority threshold |
| win_id_o | output | ID_W | Identity of the best candidate, 0 if there is none |
| win_prio_o | output | PRIO_W | Priority of the best candidate, 0 if there is none |
| irq_o | output | 1 | Interrupt request to the hart |

## Verification
On every cycle the assertions check that any reported winner was pending and enabled one cycle earlier, that its reported priority matches the priority field it had then, and that this priority is non-zero. They also check that identity and priority are zero together, that a raised request always has a winner, and that the request only rises when the winner's priority is above the previous cycle's threshold. Whether the winner is truly the best candidate cannot be seen by the assertions. The bench scenarios show this: the ordering by priority, the tie-break towards the lowest identity, that the phantom source 0 is ignored, and the request dropping after a pending flag clears.

// File: rtl/tsel_pkg.sv
// Package: shared defaults and helpers for the target selector.
// Assumes: identities fit in $clog2(N_SRC+1) bits.
package tsel_pkg;
    localparam int DEF_N_SRC  = 31;
    localparam int DEF_PRIO_W = 3;

    // Width of an identity able to hold 0..n_src.
    function automatic int id_width(input int n_src);
        return (n_src < 1) ? 1 : $clog2(n_src + 1);
    endfunction
endpackage

// File: rtl/tsel_cand.sv
// Module: builds the candidate mask. A source is a candidate when it is
// pending, enabled and has a non-zero priority. Slot 0 is never a candidate.
// Assumes: prio_i holds N_SRC+1 fields of PRIO_W bits, field k for source k.
module tsel_cand #(
    parameter int N_SRC  = tsel_pkg::DEF_N_SRC,
    parameter int PRIO_W = tsel_pkg::DEF_PRIO_W
) (
    input  logic [N_SRC:0]              pend_i,
    input  logic [N_SRC:0]              en_i,
    input  logic [(N_SRC+1)*PRIO_W-1:0] prio_i,
    output logic [N_SRC:0]              cand_o
);
    // Slot 0 stands for a source that does not exist.
    assign cand_o[0] = 1'b0;

    // Slot 0 inputs are deliberately dropped.
    logic unused_slot0;
    assign unused_slot0 = ^{pend_i[0], en_i[0], prio_i[PRIO_W-1:0]};

    // One qualifier per real source.
    for (genvar k = 1; k <= N_SRC; k++) begin : g_src
        assign cand_o[k] = pend_i[k] & en_i[k] & (|prio_i[k*PRIO_W +: PRIO_W]);
    end
endmodule

// File: rtl/tsel_arb.sv
// Module: combinational priority search over the candidate mask.
// The largest priority wins. Ties go to the lowest identity because a later
// source replaces the current best only on a strictly larger priority.
// Assumes: cand_i[0] is 0. With no candidate the outputs are 0.
module tsel_arb #(
    parameter int N_SRC  = tsel_pkg::DEF_N_SRC,
    parameter int PRIO_W = tsel_pkg::DEF_PRIO_W,
    parameter int ID_W   = tsel_pkg::id_width(N_SRC)
) (
    input  logic [N_SRC:0]              cand_i,
    input  logic [(N_SRC+1)*PRIO_W-1:0] prio_i,
    output logic [ID_W-1:0]             best_id_o,
    output logic [PRIO_W-1:0]           best_prio_o
);
    // Field 0 and the slot-0 candidate bit are never examined.
    logic unused_f0;
    assign unused_f0 = ^{prio_i[PRIO_W-1:0], cand_i[0]};

    // Linear scan from source 1 upward, keeping a strictly better source.
    always_comb begin
        best_id_o   = '0;
        best_prio_o = '0;
        for (int k = 1; k <= N_SRC; k++) begin
            if (cand_i[k] && (prio_i[k*PRIO_W +: PRIO_W] > best_prio_o)) begin
                best_prio_o = prio_i[k*PRIO_W +: PRIO_W];
                best_id_o   = ID_W'(k);
            end
        end
    end
endmodule

// File: rtl/tsel_outreg.sv
// Module: output stage. Registers the winner and derives the request from
// the unregistered winner priority against the threshold. All three outputs
// carry the same single cycle of latency.
// Assumes: synchronous active-low reset that clears every output.
module tsel_outreg #(
    parameter int PRIO_W = tsel_pkg::DEF_PRIO_W,
    parameter int ID_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   best_id_i,
    input  logic [PRIO_W-1:0] best_prio_i,
    input  logic [PRIO_W-1:0] thresh_i,
    output logic [ID_W-1:0]   win_id_o,
    output logic [PRIO_W-1:0] win_prio_o,
    output logic              irq_o
);
    logic irq_d;

    // Request only above the threshold. The threshold never touches the winner.
    assign irq_d = (best_prio_i > thresh_i);

    // Capture the winner and the request each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_id_o   <= '0;
            win_prio_o <= '0;
            irq_o      <= 1'b0;
        end else begin
            win_id_o   <= best_id_i;
            win_prio_o <= best_prio_i;
            irq_o      <= irq_d;
        end
    end
endmodule

// File: rtl/tgt_sel_top.sv
// Module: selector for one interrupt target context. It chains the candidate
// mask, the priority search and the output register.
// Assumes: the inputs are synchronous to clk. Pending storage, claim
// bookkeeping and bus access live outside this block.
module tgt_sel_top #(
    parameter int N_SRC  = tsel_pkg::DEF_N_SRC,
    parameter int PRIO_W = tsel_pkg::DEF_PRIO_W,
    parameter int ID_W   = tsel_pkg::id_width(N_SRC)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_SRC:0]              pend_i,
    input  logic [N_SRC:0]              en_i,
    input  logic [(N_SRC+1)*PRIO_W-1:0] prio_i,
    input  logic [PRIO_W-1:0]           thresh_i,
    output logic [ID_W-1:0]             win_id_o,
    output logic [PRIO_W-1:0]           win_prio_o,
    output logic                        irq_o
);
    logic [N_SRC:0]    cand;
    logic [ID_W-1:0]   best_id;
    logic [PRIO_W-1:0] best_prio;

    tsel_cand #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_cand (
        .pend_i (pend_i),
        .en_i   (en_i),
        .prio_i (prio_i),
        .cand_o (cand)
    );

    tsel_arb #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
        .cand_i      (cand),
        .prio_i      (prio_i),
        .best_id_o   (best_id),
        .best_prio_o (best_prio)
    );

    tsel_outreg #(.PRIO_W(PRIO_W), .ID_W(ID_W)) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .best_id_i   (best_id),
        .best_prio_i (best_prio),
        .thresh_i    (thresh_i),
        .win_id_o    (win_id_o),
        .win_prio_o  (win_prio_o),
        .irq_o       (irq_o)
    );
endmodule

// File: rtl/tsel_chk.sv
// Module: property checker for tgt_sel_top, attached by bind.
// It keeps its own one-cycle copies of the inputs, so each registered
// result can be related to the inputs it was computed from.
module tsel_chk #(
    parameter int N_SRC  = tsel_pkg::DEF_N_SRC,
    parameter int PRIO_W = tsel_pkg::DEF_PRIO_W,
    parameter int ID_W   = tsel_pkg::id_width(N_SRC)
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [N_SRC:0]              pend_i,
    input logic [N_SRC:0]              en_i,
    input logic [(N_SRC+1)*PRIO_W-1:0] prio_i,
    input logic [PRIO_W-1:0]           thresh_i,
    input logic [ID_W-1:0]             win_id_o,
    input logic [PRIO_W-1:0]           win_prio_o,
    input logic                        irq_o
);
    logic [N_SRC:0]              pend_q;
    logic [N_SRC:0]              en_q;
    logic [(N_SRC+1)*PRIO_W-1:0] prio_q;
    logic [PRIO_W-1:0]           thr_q;

    // Hold the previous cycle's inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            en_q   <= '0;
            prio_q <= '0;
            thr_q  <= '0;
        end else begin
            pend_q <= pend_i;
            en_q   <= en_i;
            prio_q <= prio_i;
            thr_q  <= thresh_i;
        end
    end

    // R5: a reported winner was pending and enabled.
    assert_win_qualified_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (win_id_o != '0) |-> (pend_q[win_id_o] && en_q[win_id_o]));

    // R1: a reported winner never has priority 0.
    assert_win_nonzero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (win_id_o != '0) |-> (win_prio_o != '0));

    // R2: the reported priority is that source's field from the previous cycle.
    assert_prio_matches_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (win_id_o != '0) |-> (win_prio_o == prio_q[win_id_o*PRIO_W +: PRIO_W]));

    // R8: no winner means no priority.
    assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (win_id_o == '0) |-> (win_prio_o == '0 && !irq_o));

    // R6: the request needs a winner above the previous cycle's threshold.
    assert_irq_above_thr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (win_prio_o > thr_q));

    // R6: a winner above the threshold always raises the request.
    assert_irq_when_above_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (win_prio_o > thr_q) |-> irq_o);
endmodule

bind tgt_sel_top tsel_chk #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_chk (.*);

// File: tb/tb_tgt_sel_top.sv
// Scoreboard bench: the driver applies one pattern per cycle and queues the
// expected result. The monitor pops and compares just after each edge.
module tb_tgt_sel_top;
    localparam int CLK_PERIOD = 10;
    localparam int N   = 31;
    localparam int PW  = 3;
    localparam int IW  = 5;
    localparam int WATCHDOG = 20000;

    typedef struct {
        logic [IW-1:0] id;
        logic [PW-1:0] prio;
        logic          irq;
        string         tag;
    } exp_t;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [N:0]            pend = '0;
    logic [N:0]            en = '0;
    logic [(N+1)*PW-1:0]   prio = '0;
    logic [PW-1:0]         thr = '0;
    logic [IW-1:0]         win_id;
    logic [PW-1:0]         win_prio;
    logic                  irq;

    exp_t q[$];
    exp_t last_exp;
    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;
    bit   live   = 1'b0;

    tgt_sel_top dut (
        .clk(clk), .rst_n(rst_n), .pend_i(pend), .en_i(en), .prio_i(prio),
        .thresh_i(thr), .win_id_o(win_id), .win_prio_o(win_prio), .irq_o(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference: the best candidate by the requirements, ignoring slot 0.
    function automatic exp_t model(input logic [N:0] p, input logic [N:0] e,
                                   input logic [(N+1)*PW-1:0] pr,
                                   input logic [PW-1:0] t, input string tag);
        exp_t r;
        r.id = '0; r.prio = '0; r.tag = tag;
        for (int k = 1; k <= N; k++) begin
            logic [PW-1:0] f;
            f = pr[k*PW +: PW];
            if (p[k] && e[k] && f != 0 && f > r.prio) begin
                r.prio = f;
                r.id   = IW'(k);
            end
        end
        r.irq = (r.prio > t);
        return r;
    endfunction

    // Compare one set of outputs with an expected item.
    task automatic compare(input exp_t x, input string when);
        checks++;
        if (win_id !== x.id || win_prio !== x.prio || irq !== x.irq) begin
            errors++;
            $display("FAIL %s %s: got id=%0d prio=%0d irq=%0b, want id=%0d prio=%0d irq=%0b",
                     x.tag, when, win_id, win_prio, irq, x.id, x.prio, x.irq);
        end
    endtask

    // Driver: apply one pattern at a falling edge and queue its expected item.
    // Before the next edge the outputs must still show the previous result (R9).
    task automatic drive(input logic [N:0] p, input logic [N:0] e,
                         input logic [(N+1)*PW-1:0] pr, input logic [PW-1:0] t,
                         input string tag);
        @(negedge clk);
        pend = p; en = e; prio = pr; thr = t;
        #1;
        if (live) compare(last_exp, "R9 hold before edge");
        last_exp = model(p, e, pr, t, tag);
        q.push_back(last_exp);
        live = 1'b1;
    endtask

    // Monitor: just after each edge, pop the oldest item and compare.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) compare(q.pop_front(), "after edge");
        end
    end

    function automatic logic [(N+1)*PW-1:0] setp(input logic [(N+1)*PW-1:0] v,
                                                 input int k, input int val);
        logic [(N+1)*PW-1:0] r;
        r = v;
        r[k*PW +: PW] = PW'(val);
        return r;
    endfunction

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout, want completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [(N+1)*PW-1:0] pr;
        exp_t z;
        z.id = '0; z.prio = '0; z.irq = 1'b0; z.tag = "R9 reset";
        pend = '1; en = '1; prio = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare(z, "during reset");
        rst_n = 1'b1;
        pend = '0; en = '0; prio = '0;

        // R8: nothing pending.
        drive('0, '1, '1, 3'd0, "R8 idle");
        // R5 R6: a single source with threshold 0.
        pr = setp('0, 5, 3);
        drive(32'h20, 32'h20, pr, 3'd0, "R5 R6 single source");
        // R5: pending but not enabled.
        drive(32'h20, 32'h0, pr, 3'd0, "R5 not enabled");
        // R5: enabled but not pending.
        drive(32'h0, 32'h20, pr, 3'd0, "R5 not pending");
        // R1: priority 0 alone, plus a weaker real source elsewhere.
        pr = setp('0, 9, 0);
        drive(32'h200, 32'h200, pr, 3'd0, "R1 priority zero");
        pr = setp(pr, 12, 1);
        drive(32'h1200, 32'h1200, pr, 3'd0, "R1 zero beside one");
        // R2: the larger priority wins over the lower identity.
        pr = setp(setp('0, 3, 2), 20, 6);
        drive(32'h100008, 32'h100008, pr, 3'd0, "R2 higher wins");
        // R3: a tie goes to the lowest identity.
        pr = setp(setp('0, 7, 5), 4, 5);
        drive(32'h90, 32'h90, pr, 3'd0, "R3 tie lowest id");
        // R4: slot 0 fully set with the top priority is ignored.
        pr = setp(setp('0, 0, 7), 6, 2);
        drive(32'h41, 32'h41, pr, 3'd0, "R4 slot zero ignored");
        drive(32'h1, 32'h1, pr, 3'd0, "R4 slot zero alone");
        // R7 R6: threshold equal to the winner masks only the request.
        pr = setp('0, 10, 4);
        drive(32'h400, 32'h400, pr, 3'd4, "R7 masked winner reported");
        drive(32'h400, 32'h400, pr, 3'd7, "R7 threshold max");
        drive(32'h400, 32'h400, pr, 3'd3, "R6 just above threshold");
        // Top identity at top priority.
        pr = setp(setp('0, 31, 7), 1, 7);
        drive(32'h80000000, 32'h80000000, pr, 3'd6, "R2 top id top prio");
        drive(32'h80000002, 32'h80000002, pr, 3'd6, "R3 tie at max");
        // R10: the winner's pending bit clears and the request drops next cycle.
        pr = setp(setp('0, 8, 5), 2, 1);
        drive(32'h104, 32'h104, pr, 3'd2, "R10 before clear");
        drive(32'h004, 32'h104, pr, 3'd2, "R10 after clear");

        // R2 R3 R5 R6: random patterns with a few priority levels, so ties are common.
        for (int n = 0; n < 300; n++) begin
            logic [N:0] p, e;
            p = $urandom; e = $urandom;
            pr = '0;
            for (int k = 0; k <= N; k++) pr = setp(pr, k, int'($urandom_range(0, 7)));
            drive(p, e, pr, PW'($urandom_range(0, 7)), "R2 R3 R5 R6 random");
        end

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule